// File: doc/BRIEF.md
# Receive Frame Ring Manager

This block stores received Ethernet frames in a circular region of byte-wide packet RAM and hands them to a host. A MAC-side byte stream enters with a frame-start pulse, data-valid bytes, and a closing pulse. The closing pulse is either an end strobe, which carries the CRC verdict, or an abort strobe. The ring spans from a configured first address to a configured last address, and both of those bytes belong to the ring. Writing continues past the last address at the first address, and the block never writes outside the ring.

Every frame the block keeps is prefixed by a six-byte descriptor. The descriptor gives the address where the following frame will start, the byte count of the frame, and a receive status word. The committed write pointer moves only once a frame has been written completely, together with its descriptor. An aborted frame or a dropped frame therefore leaves no trace. The host reads stored bytes through a byte read port. It releases a frame by moving its read pointer to that frame's next-frame address and then pulsing a decrement command. It polls the pending-frame count, so it does not depend on an interrupt.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset, `wr_ptr` equals `ring_start`, `pkt_cnt` is 0 and `free_bytes` equals the ring size minus one, where ring size = `ring_end - ring_start + 1`.
- R2: A stored frame begins at the old `wr_ptr` with a descriptor of three 16-bit little-endian fields in this order: the next-frame address at offsets 0 and 1, the byte count at offsets 2 and 3, and the status at offsets 4 and 5. The frame bytes follow from offset 6.
- R3: The byte count equals the number of data bytes received between start and end, including the 4 trailing CRC bytes that the MAC passes through.
- R4: Status bit 7 (offset 4, bit 7) holds the CRC-good flag sampled with the end strobe. All other status bits are 0.
- R5: The address that follows `ring_end` is `ring_start`, and no RAM write falls outside `[ring_start, ring_end]`.
- R6: On commit, `wr_ptr` becomes old `wr_ptr` + (6 + byte count, rounded up to even), wrapped into the ring. This value is even, and it is the same value stored in the descriptor.
- R7: An abort strobe leaves `wr_ptr` and `pkt_cnt` unchanged, and the next frame is stored at the same address.
- R8: A frame whose rounded span exceeds `free_bytes` is dropped: `wr_ptr` and `pkt_cnt` do not change, and unread frames stay intact.
- R9: `pkt_cnt` rises by one for each stored frame and falls by one for each `pkt_dec` pulse. A commit and a decrement in the same cycle leave it unchanged, and a decrement at 0 has no effect.
- R10: `free_bytes` = ring size - 1 - ((`wr_ptr` - host read pointer) mod ring size), and it follows writes to the host read pointer.
- R11: A frame that starts while `pkt_cnt` is at its all-ones maximum is dropped without changing `wr_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_start | input | AW | First ring address (even), stable while out of reset |
| ring_end | input | AW | Last ring address (odd), stable while out of reset |
| host_rp_wr | input | 1 | Load the host read pointer |
| host_rp_data | input | AW | New host read pointer |
| pkt_dec | input | 1 | Release one pending frame |
| rd_addr | input | AW | Host byte read address |
| rd_data | output | 8 | Byte at `rd_addr`, one cycle later |
| rx_sof | input | 1 | Frame start pulse |
| rx_valid | input | 1 | `rx_data` carries a frame byte |
| rx_data | input | 8 | Frame byte |
| rx_eof | input | 1 | Frame end pulse |
| rx_crc_ok | input | 1 | CRC verdict, valid with `rx_eof` |
| rx_abort | input | 1 | Discard the frame in progress |
| wr_ptr | output | AW | Committed write pointer |
| pkt_cnt | output | CNT_W | Pending-frame count |
| free_bytes | output | AW+1 | Bytes that may still be written |

## Verification
The bench sends frames that cross the ring's end boundary and reads them back. A design that mishandled the wrap would drop bytes past `ring_end` or move the next-frame address out of the ring. Odd lengths check the rounding: a design that skipped it would commit an odd pointer and misplace the next descriptor. Aborted frames, frames too large for the free space, and frames arriving with the counter saturated must all leave the pointer and count unchanged. A leaky design would advance `wr_ptr` or corrupt the unread descriptors that later reads compare. The bench also lands a decrement in the exact commit cycle and issues one at zero, where a wrong design would lose or wrap a count.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int HDR_BYTES = 6;
    localparam int LEN_W     = 16;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RECV,
        S_DROP,
        S_HDR
    } rx_state_e;
endpackage

// File: rtl/rxr_ram.sv
module rxr_ram #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/rxr_space.sv
module rxr_space #(
    parameter int AW = 10
) (
    input  logic [AW-1:0] ring_start,
    input  logic [AW-1:0] ring_end,
    input  logic [AW-1:0] wp,
    input  logic [AW-1:0] rp,
    output logic [AW:0]   ring_size,
    output logic [AW:0]   free
);
    logic [AW:0] used;

    always_comb begin
        ring_size = {1'b0, ring_end} - {1'b0, ring_start} + 1'b1;
        if (wp >= rp) begin
            used = {1'b0, wp} - {1'b0, rp};
        end else begin
            used = {1'b0, wp} + ring_size - {1'b0, rp};
        end
        free = ring_size - 1'b1 - used;
    end
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
    import rxr_pkg::*;
#(
    parameter int AW    = 10,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ring_start,
    input  logic [AW-1:0]    ring_end,
    input  logic [AW:0]      ring_size,
    input  logic [AW:0]      free,
    input  logic             host_rp_wr,
    input  logic [AW-1:0]    host_rp_data,
    input  logic             pkt_dec,
    input  logic             rx_sof,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_eof,
    input  logic             rx_crc_ok,
    input  logic             rx_abort,
    output logic             mem_we,
    output logic [AW-1:0]    mem_wa,
    output logic [7:0]       mem_wd,
    output logic [AW-1:0]    wp,
    output logic [AW-1:0]    rp,
    output logic [CNT_W-1:0] cnt
);
    localparam int CW = ((LEN_W > AW) ? LEN_W : AW) + 2;

    typedef struct packed {
        rx_state_e        st;
        logic [AW-1:0]    wp;
        logic [AW-1:0]    rp;
        logic [AW-1:0]    tp;
        logic [AW-1:0]    nxt;
        logic [LEN_W-1:0] len;
        logic [2:0]       hcnt;
        logic             crc_ok;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t q, d;

    // Advance an in-ring address by k (k below ring size), folding past the end.
    function automatic logic [AW-1:0] fwd(input logic [AW-1:0] a,
                                          input logic [AW:0]   k,
                                          input logic [AW-1:0] last,
                                          input logic [AW:0]   size);
        logic [AW+1:0] s;
        s = {2'b00, a} + {1'b0, k};
        if (s > {2'b00, last}) begin
            s = s - {1'b0, size};
        end
        return s[AW-1:0];
    endfunction

    logic [CW-1:0] need_byte;
    logic [CW-1:0] span_even;
    logic [CW-1:0] free_w;
    logic [15:0]   nxt16;
    logic [7:0]    hdr_byte;
    logic          inc;
    logic          dec_ok;

    always_comb begin
        d        = q;
        mem_we   = 1'b0;
        mem_wa   = q.tp;
        mem_wd   = rx_data;
        inc      = 1'b0;

        free_w    = CW'(free);
        need_byte = CW'(HDR_BYTES) + CW'(q.len) + CW'(1);
        span_even = CW'(HDR_BYTES) + CW'(q.len);
        if (span_even[0]) begin
            span_even = span_even + CW'(1);
        end

        nxt16 = 16'(q.nxt);
        case (q.hcnt)
            3'd0:    hdr_byte = nxt16[7:0];
            3'd1:    hdr_byte = nxt16[15:8];
            3'd2:    hdr_byte = q.len[7:0];
            3'd3:    hdr_byte = q.len[15:8];
            3'd4:    hdr_byte = {q.crc_ok, 7'b0};
            default: hdr_byte = 8'h00;
        endcase

        if (host_rp_wr) begin
            d.rp = host_rp_data;
        end

        case (q.st)
            S_IDLE: begin
                if (rx_sof) begin
                    if (&q.cnt) begin
                        d.st = S_DROP;
                    end else begin
                        d.st  = S_RECV;
                        d.tp  = fwd(q.wp, (AW+1)'(HDR_BYTES), ring_end, ring_size);
                        d.len = '0;
                    end
                end
            end
            S_RECV: begin
                if (rx_abort) begin
                    d.st = S_IDLE;
                end else if (rx_valid) begin
                    if (need_byte > free_w) begin
                        d.st = S_DROP;
                    end else begin
                        mem_we = 1'b1;
                        mem_wa = q.tp;
                        d.tp   = fwd(q.tp, (AW+1)'(1), ring_end, ring_size);
                        d.len  = q.len + 1'b1;
                    end
                end else if (rx_eof) begin
                    if (span_even > free_w) begin
                        d.st = S_IDLE;
                    end else begin
                        d.st     = S_HDR;
                        d.nxt    = fwd(q.wp, span_even[AW:0], ring_end, ring_size);
                        d.crc_ok = rx_crc_ok;
                        d.hcnt   = '0;
                    end
                end
            end
            S_DROP: begin
                if (rx_eof || rx_abort) begin
                    d.st = S_IDLE;
                end
            end
            S_HDR: begin
                mem_we = 1'b1;
                mem_wa = fwd(q.wp, (AW+1)'(q.hcnt), ring_end, ring_size);
                mem_wd = hdr_byte;
                d.hcnt = q.hcnt + 1'b1;
                if (q.hcnt == 3'(HDR_BYTES - 1)) begin
                    d.wp = q.nxt;
                    d.st = S_IDLE;
                    inc  = 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase

        dec_ok = pkt_dec && (q.cnt != '0);
        d.cnt  = q.cnt + CNT_W'(inc) - CNT_W'(dec_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= S_IDLE;
            q.wp     <= ring_start;
            q.rp     <= ring_start;
        end else begin
            q <= d;
        end
    end

    assign wp  = q.wp;
    assign rp  = q.rp;
    assign cnt = q.cnt;
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr #(
    parameter int AW    = 10,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ring_start,
    input  logic [AW-1:0]    ring_end,
    input  logic             host_rp_wr,
    input  logic [AW-1:0]    host_rp_data,
    input  logic             pkt_dec,
    input  logic [AW-1:0]    rd_addr,
    output logic [7:0]       rd_data,
    input  logic             rx_sof,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_eof,
    input  logic             rx_crc_ok,
    input  logic             rx_abort,
    output logic [AW-1:0]    wr_ptr,
    output logic [CNT_W-1:0] pkt_cnt,
    output logic [AW:0]      free_bytes
);
    logic          mem_we;
    logic [AW-1:0] mem_wa;
    logic [7:0]    mem_wd;
    logic [AW-1:0] host_rp;
    logic [AW:0]   ring_size;

    rxr_space #(.AW(AW)) space_i (
        .ring_start (ring_start),
        .ring_end   (ring_end),
        .wp         (wr_ptr),
        .rp         (host_rp),
        .ring_size  (ring_size),
        .free       (free_bytes)
    );

    rxr_ctrl #(.AW(AW), .CNT_W(CNT_W)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ring_start   (ring_start),
        .ring_end     (ring_end),
        .ring_size    (ring_size),
        .free         (free_bytes),
        .host_rp_wr   (host_rp_wr),
        .host_rp_data (host_rp_data),
        .pkt_dec      (pkt_dec),
        .rx_sof       (rx_sof),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_eof       (rx_eof),
        .rx_crc_ok    (rx_crc_ok),
        .rx_abort     (rx_abort),
        .mem_we       (mem_we),
        .mem_wa       (mem_wa),
        .mem_wd       (mem_wd),
        .wp           (wr_ptr),
        .rp           (host_rp),
        .cnt          (pkt_cnt)
    );

    rxr_ram #(.AW(AW)) ram_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_wa),
        .wdata (mem_wd),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/rxr_chk.sv
module rxr_chk #(
    parameter int AW    = 10,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    ring_start,
    input logic [AW-1:0]    ring_end,
    input logic             mem_we,
    input logic [AW-1:0]    mem_wa,
    input logic [AW-1:0]    wr_ptr,
    input logic [CNT_W-1:0] pkt_cnt,
    input logic [AW:0]      free_bytes,
    input logic             rx_abort,
    input logic             pkt_dec
);
    assert_write_in_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wa >= ring_start && mem_wa <= ring_end));

    assert_wp_in_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr >= ring_start && wr_ptr <= ring_end));

    assert_wp_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_ptr) |-> !wr_ptr[0]);

    assert_abort_keeps_wp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_abort |=> $stable(wr_ptr));

    assert_cnt_unit_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, pkt_cnt} == {1'b0, $past(pkt_cnt)}) ||
        ({1'b0, pkt_cnt} == {1'b0, $past(pkt_cnt)} + 1'b1) ||
        ({1'b0, pkt_cnt} + 1'b1 == {1'b0, $past(pkt_cnt)}));

    assert_dec_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_cnt == '0 && pkt_dec) |=> (pkt_cnt <= CNT_W'(1)));

    assert_free_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        free_bytes <= ({1'b0, ring_end} - {1'b0, ring_start}));
endmodule

bind rx_ring_mgr rxr_chk #(.AW(AW), .CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ring_start (ring_start),
    .ring_end   (ring_end),
    .mem_we     (mem_we),
    .mem_wa     (mem_wa),
    .wr_ptr     (wr_ptr),
    .pkt_cnt    (pkt_cnt),
    .free_bytes (free_bytes),
    .rx_abort   (rx_abort),
    .pkt_dec    (pkt_dec)
);

// File: tb/rx_ring_mgr_tb_top.sv
module rx_ring_mgr_tb_top;
    localparam int AW    = 10;
    localparam int CNT_W = 4;
    localparam int RS    = 100;
    localparam int RE    = 355;
    localparam int N     = RE - RS + 1;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [AW-1:0]    ring_start = AW'(RS);
    logic [AW-1:0]    ring_end   = AW'(RE);
    logic             host_rp_wr = 1'b0;
    logic [AW-1:0]    host_rp_data = '0;
    logic             pkt_dec = 1'b0;
    logic [AW-1:0]    rd_addr = '0;
    logic [7:0]       rd_data;
    logic             rx_sof = 1'b0;
    logic             rx_valid = 1'b0;
    logic [7:0]       rx_data = '0;
    logic             rx_eof = 1'b0;
    logic             rx_crc_ok = 1'b0;
    logic             rx_abort = 1'b0;
    logic [AW-1:0]    wr_ptr;
    logic [CNT_W-1:0] pkt_cnt;
    logic [AW:0]      free_bytes;

    rx_ring_mgr #(.AW(AW), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ring_start(ring_start), .ring_end(ring_end),
        .host_rp_wr(host_rp_wr), .host_rp_data(host_rp_data), .pkt_dec(pkt_dec),
        .rd_addr(rd_addr), .rd_data(rd_data), .rx_sof(rx_sof), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok), .rx_abort(rx_abort),
        .wr_ptr(wr_ptr), .pkt_cnt(pkt_cnt), .free_bytes(free_bytes)
    );

    int total = 0;
    int fails = 0;
    int mwp, mrp, mcnt;
    int fq_s[32];
    int fq_n[32];
    int qh = 0;
    int qt = 0;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int wrapb(input int a, input int k);
        int r;
        r = a + k;
        if (r > RE) r -= N;
        return r;
    endfunction

    function automatic int mfree();
        int u;
        u = (mwp >= mrp) ? (mwp - mrp) : (mwp + N - mrp);
        return N - 1 - u;
    endfunction

    task automatic rd(input int a, output int v);
        rd_addr = AW'(a);
        tick();
        v = int'(rd_data);
    endtask

    task automatic check_state(input string tag);
        chk({tag, " R6 wr_ptr"}, int'(wr_ptr), mwp);
        chk({tag, " R9 pkt_cnt"}, int'(pkt_cnt), mcnt);
        chk({tag, " R10 free_bytes"}, int'(free_bytes), mfree());
    endtask

    task automatic send_frame(input int len, input bit ok, input int abort_at,
                              input bit dec_commit);
        logic [7:0] fb [64];
        int fr, span, nxt, v, old_wp;
        bit ab, store, wraps;
        fr = mfree();
        ab = 1'b0;
        for (int i = 0; i < len; i++) fb[i] = 8'($urandom_range(0, 255));
        rx_sof = 1'b1; tick(); rx_sof = 1'b0;
        for (int i = 0; i < len; i++) begin
            if (i == abort_at) begin
                rx_abort = 1'b1; tick(); rx_abort = 1'b0;
                ab = 1'b1;
                break;
            end
            rx_valid = 1'b1; rx_data = fb[i]; tick(); rx_valid = 1'b0;
        end
        if (!ab) begin
            rx_eof = 1'b1; rx_crc_ok = ok; tick(); rx_eof = 1'b0; rx_crc_ok = 1'b0;
            if (dec_commit) begin
                repeat (5) tick();
                pkt_dec = 1'b1; tick(); pkt_dec = 1'b0;
            end
        end
        repeat (8) tick();

        span = 6 + len + ((6 + len) % 2);
        store = !ab && (mcnt < MAXC) && (span <= fr);
        old_wp = mwp;
        if (store) begin
            nxt = wrapb(mwp, span);
            mwp = nxt;
            mcnt = mcnt + 1 - (dec_commit ? 1 : 0);
            fq_s[qt] = old_wp; fq_n[qt] = nxt; qt = (qt + 1) % 32;
        end
        if (ab) check_state("R7 abort");
        else if (!store && mcnt >= MAXC) check_state("R11 count full");
        else if (!store) check_state("R8 overflow drop");
        else check_state("stored");

        if (store) begin
            nxt = fq_n[(qt + 31) % 32];
            rd(old_wp, v);             chk("R2 next lo", v, nxt & 255);
            rd(wrapb(old_wp, 1), v);   chk("R2 next hi", v, nxt >> 8);
            rd(wrapb(old_wp, 2), v);   chk("R3 len lo", v, len & 255);
            rd(wrapb(old_wp, 3), v);   chk("R3 len hi", v, len >> 8);
            rd(wrapb(old_wp, 4), v);   chk("R4 status lo", v, ok ? 128 : 0);
            rd(wrapb(old_wp, 5), v);   chk("R4 status hi", v, 0);
            wraps = (old_wp + 6 + len - 1) > RE;
            for (int i = 0; i < len; i++) begin
                rd(wrapb(old_wp, 6 + i), v);
                chk(wraps ? "R5 wrapped data" : "R2 data", v, int'(fb[i]));
            end
        end
    endtask

    task automatic consume(input bit dodec);
        int s, lo, hi;
        if (qh == qt) return;
        s = fq_s[qh];
        rd(s, lo);
        rd(wrapb(s, 1), hi);
        chk("R8 R2 unread next ptr intact", lo + 256 * hi, fq_n[qh]);
        host_rp_wr = 1'b1; host_rp_data = AW'(fq_n[qh]); tick(); host_rp_wr = 1'b0;
        mrp = fq_n[qh];
        qh = (qh + 1) % 32;
        if (dodec) begin
            pkt_dec = 1'b1; tick(); pkt_dec = 1'b0;
            mcnt--;
        end
        check_state("consume");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'h1a2b3c4d));
        mwp = RS; mrp = RS; mcnt = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 reset wr_ptr", int'(wr_ptr), RS);
        chk("R1 reset pkt_cnt", int'(pkt_cnt), 0);
        chk("R1 reset free", int'(free_bytes), N - 1);

        send_frame(5, 1'b1, -1, 1'b0);   // odd length: rounding
        send_frame(20, 1'b1, 7, 1'b0);   // R7 abort mid frame
        send_frame(12, 1'b0, -1, 1'b0);  // bad CRC, same place as aborted one
        consume(1'b1);
        consume(1'b1);

        for (int k = 0; k < 80; k++) begin
            send_frame($urandom_range(4, 60), 1'($urandom_range(0, 1)),
                       ($urandom_range(0, 6) == 0) ? $urandom_range(0, 3) : -1, 1'b0);
            if ($urandom_range(0, 9) < 4) consume(1'b1);
        end

        while (qh != qt) consume(1'b1);
        for (int k = 0; k <= MAXC; k++) send_frame(4, 1'b1, -1, 1'b0);  // R11
        while (qh != qt) consume(1'b1);

        pkt_dec = 1'b1; tick(); pkt_dec = 1'b0; tick();
        chk("R9 decrement at zero", int'(pkt_cnt), 0);

        send_frame(9, 1'b1, -1, 1'b0);
        consume(1'b0);
        send_frame(10, 1'b1, -1, 1'b1);  // R9 decrement in commit cycle
        chk("R9 simultaneous commit and decrement", int'(pkt_cnt), 1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule